// File: doc/BRIEF.md
# Control Transfer Type Classifier

This block gives a label to each retired control-flow event, so that a branch trace recorder further down the pipeline can file it. The retire stage sends it one event per cycle at most. Each event carries a coarse kind, the destination and first source register indices, a few qualifier flags, and the source and target program counters. One cycle after the block accepts an event, it presents a valid pulse with a 4-bit transfer type code and the two PCs.

The block does not decode raw opcodes and does not store records. The retire stage reports the coarse kind. The block refines it using the register indices. Registers x1 and x5 are link registers, and x0 is the zero register. For indirect jumps, the way rd and rs1 fall on the two link registers decides between call, return, co-routine swap, plain jump and other jump. For not-taken branches, the block replaces the target with the next sequential PC.

Top module: `xfer_type_classifier`

## Requirements
- R1: During and right after reset, out_valid is 0 and out_type is 0 (none).
- R2: An event with ev_valid=1 and a legal ev_kind (0 to 5) gives out_valid=1 exactly one clock edge later. In every other cycle out_valid is 0.
- R3: ev_kind=1 (indirect) with rd=x1 and rs1 not x5, or with rd=x5 and rs1 not x1, gives type 8 (indirect call).
- R4: ev_kind=1 with rd=x0 and rs1 neither x1 nor x5 gives type 10 (indirect jump).
- R5: ev_kind=1 with rs1 equal to x1 or x5 and rd neither x1 nor x5 gives type 13 (return).
- R6: ev_kind=1 with rd=x1 and rs1=x5, or with rd=x5 and rs1=x1, gives type 12 (co-routine swap).
- R7: Any other ev_kind=1 event gives type 14 (other indirect jump).
- R8: ev_kind=0 (direct) gives type 9 when rd is x1 or x5, type 11 when rd is x0, and type 15 for any other rd.
- R9: ev_kind=3 (pop with return) always gives type 13, whatever rd and rs1 hold.
- R10: ev_kind=2 (branch) gives type 5 with out_tgt=tgt_pc when ev_taken=1. When ev_taken=0 it gives type 4 with out_tgt equal to src_pc plus 2 if ev_compressed=1, or plus 4 otherwise.
- R11: ev_kind=4 (trap) gives type 2 when ev_async=1 and type 1 otherwise. ev_kind=5 (trap return) gives type 3.
- R12: For every accepted event, out_src equals src_pc. For every accepted event except a not-taken branch, out_tgt equals tgt_pc.
- R13: In a cycle after no accepted event, out_type is 0. This holds when ev_valid=0, and also when ev_kind is 6 or 7 with ev_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is offered this cycle |
| ev_kind | input | 3 | 0 direct, 1 indirect, 2 branch, 3 pop-return, 4 trap, 5 trap return, 6-7 reserved |
| ev_taken | input | 1 | Branch outcome, used by kind 2 |
| ev_async | input | 1 | Trap is an interrupt, used by kind 4 |
| ev_compressed | input | 1 | Instruction is 2 bytes long, used for the next sequential PC |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | First source register index |
| src_pc | input | XLEN | PC of the transferring instruction |
| tgt_pc | input | XLEN | Destination PC |
| out_valid | output | 1 | Classified record is present |
| out_type | output | 4 | Transfer type code |
| out_src | output | XLEN | Registered source PC |
| out_tgt | output | XLEN | Registered target PC, sequential PC for a not-taken branch |

## Verification
The assertions assume that the retire stage holds all event fields stable only in the cycle that ev_valid is high. They also assume that the PCs stay far enough from the top of the address space that adding 4 does not wrap in a way that matters. The bench drives each event at the falling edge, so the fields are settled before the capturing edge. It keeps src_pc in a low range, and it sends the register pairs that sit on the link-register boundaries as well as a sweep of all 32 by 32 index pairs for the indirect kind. Reserved kinds and idle cycles are placed between real events, so the one-cycle valid pulse is never mistaken for a held level.

// File: rtl/xfer_cls_pkg.sv
package xfer_cls_pkg;

  localparam int unsigned KIND_W = 3;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned IDX_W  = 5;

  localparam logic [KIND_W-1:0] KIND_DIRECT   = 3'd0;
  localparam logic [KIND_W-1:0] KIND_INDIRECT = 3'd1;
  localparam logic [KIND_W-1:0] KIND_BRANCH   = 3'd2;
  localparam logic [KIND_W-1:0] KIND_POPRET   = 3'd3;
  localparam logic [KIND_W-1:0] KIND_TRAP     = 3'd4;
  localparam logic [KIND_W-1:0] KIND_TRET     = 3'd5;
  localparam logic [KIND_W-1:0] KIND_LAST     = KIND_TRET;

  localparam logic [IDX_W-1:0] LINK_PRIMARY   = 5'd1;
  localparam logic [IDX_W-1:0] LINK_ALTERNATE = 5'd5;

  typedef enum logic [CODE_W-1:0] {
    XT_NONE       = 4'd0,
    XT_EXCEPTION  = 4'd1,
    XT_INTERRUPT  = 4'd2,
    XT_TRAP_RET   = 4'd3,
    XT_BR_NOTTAKE = 4'd4,
    XT_BR_TAKEN   = 4'd5,
    XT_IND_CALL   = 4'd8,
    XT_DIR_CALL   = 4'd9,
    XT_IND_JUMP   = 4'd10,
    XT_DIR_JUMP   = 4'd11,
    XT_CO_SWAP    = 4'd12,
    XT_RETURN     = 4'd13,
    XT_IND_OTHER  = 4'd14,
    XT_DIR_OTHER  = 4'd15
  } xfer_code_e;

  function automatic logic kind_is_legal(input logic [KIND_W-1:0] k);
    return k <= KIND_LAST;
  endfunction

  // Indirect refinement from link-register hits of rd and rs1.
  function automatic xfer_code_e indirect_code(
    input logic rd_pri, input logic rd_alt, input logic rd_zero,
    input logic rs_pri, input logic rs_alt);
    logic rd_link;
    logic rs_link;
    rd_link = rd_pri | rd_alt;
    rs_link = rs_pri | rs_alt;
    if ((rd_pri && !rs_alt) || (rd_alt && !rs_pri)) return XT_IND_CALL;
    if (rd_zero && !rs_link)                         return XT_IND_JUMP;
    if (rs_link && !rd_link)                         return XT_RETURN;
    if ((rd_pri && rs_alt) || (rd_alt && rs_pri))    return XT_CO_SWAP;
    return XT_IND_OTHER;
  endfunction

  function automatic xfer_code_e direct_code(
    input logic rd_link, input logic rd_zero);
    if (rd_link) return XT_DIR_CALL;
    if (rd_zero) return XT_DIR_JUMP;
    return XT_DIR_OTHER;
  endfunction

  function automatic xfer_code_e trap_code(input logic is_async);
    return is_async ? XT_INTERRUPT : XT_EXCEPTION;
  endfunction

  function automatic xfer_code_e branch_code(input logic taken);
    return taken ? XT_BR_TAKEN : XT_BR_NOTTAKE;
  endfunction

endpackage

// File: rtl/xfer_link_decode.sv
module xfer_link_decode #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic             hit_pri,
  output logic             hit_alt
);
  import xfer_cls_pkg::*;

  always_comb begin
    hit_pri = (idx == IDX_W'(LINK_PRIMARY));
    hit_alt = (idx == IDX_W'(LINK_ALTERNATE));
  end

endmodule

// File: rtl/xfer_type_select.sv
module xfer_type_select #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned KIND_W = 3,
  parameter int unsigned CODE_W = 4
) (
  input  logic [KIND_W-1:0] kind,
  input  logic              taken,
  input  logic              is_async,
  input  logic              compressed,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_pri,
  input  logic              rd_alt,
  input  logic              rs_pri,
  input  logic              rs_alt,
  input  logic [XLEN-1:0]   src_pc,
  input  logic [XLEN-1:0]   tgt_pc,
  output logic              legal,
  output logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   tgt_sel
);
  import xfer_cls_pkg::*;

  localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(2);
  localparam logic [XLEN-1:0] STEP_LONG  = XLEN'(4);

  function automatic logic [XLEN-1:0] seq_next(
    input logic [XLEN-1:0] pc, input logic short_insn);
    return pc + (short_insn ? STEP_SHORT : STEP_LONG);
  endfunction

  logic       rd_zero;
  xfer_code_e sel;

  always_comb begin
    rd_zero = (rd_idx == '0);
    legal   = kind_is_legal(kind);
    tgt_sel = tgt_pc;
    unique case (kind)
      KIND_DIRECT:   sel = direct_code(rd_pri | rd_alt, rd_zero);
      KIND_INDIRECT: sel = indirect_code(rd_pri, rd_alt, rd_zero, rs_pri, rs_alt);
      KIND_BRANCH: begin
        sel = branch_code(taken);
        if (!taken) tgt_sel = seq_next(src_pc, compressed);
      end
      KIND_POPRET:   sel = XT_RETURN;
      KIND_TRAP:     sel = trap_code(is_async);
      KIND_TRET:     sel = XT_TRAP_RET;
      default:       sel = XT_NONE;
    endcase
    code = CODE_W'(sel);
  end

endmodule

// File: rtl/xfer_stage_reg.sv
module xfer_stage_reg #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/xfer_type_classifier.sv
module xfer_type_classifier #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  logic [2:0]      ev_kind,
  input  logic            ev_taken,
  input  logic            ev_async,
  input  logic            ev_compressed,
  input  logic [4:0]      rd_idx,
  input  logic [4:0]      rs1_idx,
  input  logic [XLEN-1:0] src_pc,
  input  logic [XLEN-1:0] tgt_pc,
  output logic            out_valid,
  output logic [3:0]      out_type,
  output logic [XLEN-1:0] out_src,
  output logic [XLEN-1:0] out_tgt
);
  import xfer_cls_pkg::*;

  localparam int unsigned NUM_IDX = 2;

  // Named internal events, observed by the bound checker.
  logic              rd_is_pri, rd_is_alt, rs_is_pri, rs_is_alt;
  logic              kind_ok;
  logic              ev_fire;
  logic [CODE_W-1:0] next_code;
  logic [XLEN-1:0]   next_tgt;

  logic [IDX_W-1:0] idx_vec [NUM_IDX];
  logic [NUM_IDX-1:0] pri_vec, alt_vec;

  assign idx_vec[0] = rd_idx;
  assign idx_vec[1] = rs1_idx;

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_link
    xfer_link_decode #(.IDX_W(IDX_W)) dec_i (
      .idx     (idx_vec[g]),
      .hit_pri (pri_vec[g]),
      .hit_alt (alt_vec[g])
    );
  end

  assign rd_is_pri = pri_vec[0];
  assign rd_is_alt = alt_vec[0];
  assign rs_is_pri = pri_vec[1];
  assign rs_is_alt = alt_vec[1];

  xfer_type_select #(
    .XLEN(XLEN), .IDX_W(IDX_W), .KIND_W(KIND_W), .CODE_W(CODE_W)
  ) sel_i (
    .kind       (ev_kind),
    .taken      (ev_taken),
    .is_async   (ev_async),
    .compressed (ev_compressed),
    .rd_idx     (rd_idx),
    .rd_pri     (rd_is_pri),
    .rd_alt     (rd_is_alt),
    .rs_pri     (rs_is_pri),
    .rs_alt     (rs_is_alt),
    .src_pc     (src_pc),
    .tgt_pc     (tgt_pc),
    .legal      (kind_ok),
    .code       (next_code),
    .tgt_sel    (next_tgt)
  );

  assign ev_fire = ev_valid & kind_ok;

  logic [CODE_W:0] vt_d, vt_q;
  assign vt_d = ev_fire ? {1'b1, next_code} : {1'b0, CODE_W'(XT_NONE)};

  xfer_stage_reg #(.W(CODE_W + 1)) vt_reg_i (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .d(vt_d), .q(vt_q)
  );

  xfer_stage_reg #(.W(XLEN)) src_reg_i (
    .clk(clk), .rst_n(rst_n), .en(ev_fire), .d(src_pc), .q(out_src)
  );

  xfer_stage_reg #(.W(XLEN)) tgt_reg_i (
    .clk(clk), .rst_n(rst_n), .en(ev_fire), .d(next_tgt), .q(out_tgt)
  );

  assign out_valid = vt_q[CODE_W];
  assign out_type  = vt_q[CODE_W-1:0];

endmodule

// File: rtl/xfer_type_classifier_chk.sv
module xfer_type_classifier_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_valid,
  input logic [2:0]      ev_kind,
  input logic            ev_compressed,
  input logic            ev_taken,
  input logic [XLEN-1:0] src_pc,
  input logic [XLEN-1:0] tgt_pc,
  input logic            rd_is_pri,
  input logic            rd_is_alt,
  input logic            rs_is_pri,
  input logic            rs_is_alt,
  input logic            out_valid,
  input logic [3:0]      out_type,
  input logic [XLEN-1:0] out_src,
  input logic [XLEN-1:0] out_tgt
);
  logic ok_kind;
  assign ok_kind = (ev_kind <= 3'd5);

  a_r2_fire_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ok_kind) |=> out_valid);

  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ok_kind) |=> !out_valid);

  a_r13_idle_type: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_type == 4'd0));

  a_r3_ind_call: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 3'd1 &&
     ((rd_is_pri && !rs_is_alt) || (rd_is_alt && !rs_is_pri)))
    |=> (out_type == 4'd8));

  a_r6_co_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 3'd1 &&
     ((rd_is_pri && rs_is_alt) || (rd_is_alt && rs_is_pri)))
    |=> (out_type == 4'd12));

  a_r9_popret: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 3'd3) |=> (out_type == 4'd13));

  a_r11_trap_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 3'd5) |=> (out_type == 4'd3));

  a_r10_seq_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 3'd2 && !ev_taken)
    |=> (out_tgt == $past(src_pc) + ($past(ev_compressed) ? XLEN'(2) : XLEN'(4))));

  a_r12_src_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ok_kind) |=> (out_src == $past(src_pc)));

  a_r12_tgt_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ok_kind && !(ev_kind == 3'd2 && !ev_taken))
    |=> (out_tgt == $past(tgt_pc)));

endmodule

bind xfer_type_classifier xfer_type_classifier_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
  .ev_compressed(ev_compressed), .ev_taken(ev_taken),
  .src_pc(src_pc), .tgt_pc(tgt_pc),
  .rd_is_pri(rd_is_pri), .rd_is_alt(rd_is_alt),
  .rs_is_pri(rs_is_pri), .rs_is_alt(rs_is_alt),
  .out_valid(out_valid), .out_type(out_type),
  .out_src(out_src), .out_tgt(out_tgt)
);

// File: tb/xfer_type_classifier_tb.sv
module xfer_type_classifier_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [2:0] ev_kind = '0;
  logic ev_taken = 1'b0, ev_async = 1'b0, ev_compressed = 1'b0;
  logic [4:0] rd_idx = '0, rs1_idx = '0;
  logic [XLEN-1:0] src_pc = '0, tgt_pc = '0;
  logic out_valid;
  logic [3:0] out_type;
  logic [XLEN-1:0] out_src, out_tgt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic            q_v[$];
  logic [3:0]      q_t[$];
  logic [XLEN-1:0] q_s[$];
  logic [XLEN-1:0] q_g[$];
  string           q_r[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_type_classifier #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_taken(ev_taken), .ev_async(ev_async), .ev_compressed(ev_compressed),
    .rd_idx(rd_idx), .rs1_idx(rs1_idx), .src_pc(src_pc), .tgt_pc(tgt_pc),
    .out_valid(out_valid), .out_type(out_type),
    .out_src(out_src), .out_tgt(out_tgt)
  );

  function automatic bit lnk(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

  // Reference model written from the requirement text, in its own order.
  function automatic logic [3:0] model(input logic [2:0] k, input logic tk,
      input logic as, input logic [4:0] rd, input logic [4:0] rs);
    case (k)
      3'd0: return lnk(rd) ? 4'd9 : (rd == 0 ? 4'd11 : 4'd15);
      3'd1: begin
        if (lnk(rd) && lnk(rs) && rd != rs) return 4'd12;
        if (lnk(rd))                        return 4'd8;
        if (lnk(rs))                        return 4'd13;
        if (rd == 0)                        return 4'd10;
        return 4'd14;
      end
      3'd2: return tk ? 4'd5 : 4'd4;
      3'd3: return 4'd13;
      3'd4: return as ? 4'd2 : 4'd1;
      3'd5: return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

  task automatic drive(input logic v, input logic [2:0] k, input logic tk,
      input logic as, input logic cm, input logic [4:0] rd, input logic [4:0] rs,
      input logic [XLEN-1:0] s, input logic [XLEN-1:0] g, input string req);
    logic ev;
    @(negedge clk);
    ev_valid = v; ev_kind = k; ev_taken = tk; ev_async = as;
    ev_compressed = cm; rd_idx = rd; rs1_idx = rs; src_pc = s; tgt_pc = g;
    ev = v && (k <= 3'd5);
    q_v.push_back(ev);
    q_t.push_back(ev ? model(k, tk, as, rd, rs) : 4'd0);
    q_s.push_back(s);
    q_g.push_back((k == 3'd2 && !tk) ? s + (cm ? 32'd2 : 32'd4) : g);
    q_r.push_back(req);
  endtask

  task automatic idle();
    drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, '0, '0, "R13");
  endtask

  // Monitor: compare one scoreboard entry per cycle, after the capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_v.size() != 0) begin
        logic ev; logic [3:0] et; logic [XLEN-1:0] es, eg; string rq;
        ev = q_v.pop_front(); et = q_t.pop_front();
        es = q_s.pop_front(); eg = q_g.pop_front(); rq = q_r.pop_front();
        checks++;
        if (out_valid !== ev || out_type !== et) begin
          errors++;
          $display("FAIL %s: valid/type got %0b/%0d expected %0b/%0d",
                   rq, out_valid, out_type, ev, et);
        end
        if (ev) begin
          checks++;
          if (out_src !== es || out_tgt !== eg) begin
            errors++;
            $display("FAIL %s R12: src/tgt got %h/%h expected %h/%h",
                     rq, out_src, out_tgt, es, eg);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_type !== 4'd0) begin
      errors++;
      $display("FAIL R1: valid/type got %0b/%0d expected 0/0", out_valid, out_type);
    end
    rst_n = 1'b1;

    // R3 indirect calls, including both link registers on both sides
    drive(1, 3'd1, 0, 0, 0, 5'd1, 5'd7, 32'h100, 32'h2000, "R3");
    drive(1, 3'd1, 0, 0, 0, 5'd5, 5'd5, 32'h104, 32'h2004, "R3");
    drive(1, 3'd1, 0, 0, 0, 5'd1, 5'd1, 32'h108, 32'h2008, "R3");
    // R4 plain indirect jump
    drive(1, 3'd1, 0, 0, 0, 5'd0, 5'd6, 32'h10c, 32'h200c, "R4");
    drive(1, 3'd1, 0, 0, 0, 5'd0, 5'd0, 32'h110, 32'h2010, "R4");
    // R5 returns
    drive(1, 3'd1, 0, 0, 0, 5'd0, 5'd1, 32'h114, 32'h2014, "R5");
    drive(1, 3'd1, 0, 0, 0, 5'd9, 5'd5, 32'h118, 32'h2018, "R5");
    // R6 co-routine swaps
    drive(1, 3'd1, 0, 0, 0, 5'd1, 5'd5, 32'h11c, 32'h201c, "R6");
    drive(1, 3'd1, 0, 0, 0, 5'd5, 5'd1, 32'h120, 32'h2020, "R6");
    // R7 other indirect
    drive(1, 3'd1, 0, 0, 0, 5'd2, 5'd3, 32'h124, 32'h2024, "R7");
    idle();
    // R8 direct kinds
    drive(1, 3'd0, 0, 0, 0, 5'd1, 5'd3, 32'h200, 32'h3000, "R8");
    drive(1, 3'd0, 0, 0, 0, 5'd5, 5'd0, 32'h204, 32'h3004, "R8");
    drive(1, 3'd0, 0, 0, 0, 5'd0, 5'd1, 32'h208, 32'h3008, "R8");
    drive(1, 3'd0, 0, 0, 0, 5'd31, 5'd5, 32'h20c, 32'h300c, "R8");
    // R9 pop-return ignores indices
    drive(1, 3'd3, 0, 0, 0, 5'd1, 5'd5, 32'h210, 32'h3010, "R9");
    drive(1, 3'd3, 1, 1, 0, 5'd0, 5'd0, 32'h214, 32'h3014, "R9");
    // R10 branches
    drive(1, 3'd2, 1, 0, 0, 5'd0, 5'd0, 32'h300, 32'h4000, "R10");
    drive(1, 3'd2, 0, 0, 0, 5'd0, 5'd0, 32'h304, 32'h4004, "R10");
    drive(1, 3'd2, 0, 0, 1, 5'd1, 5'd5, 32'h30a, 32'h4008, "R10");
    // R11 traps and trap returns
    drive(1, 3'd4, 0, 1, 0, 5'd0, 5'd0, 32'h400, 32'h5000, "R11");
    drive(1, 3'd4, 0, 0, 0, 5'd0, 5'd0, 32'h404, 32'h5004, "R11");
    drive(1, 3'd5, 0, 0, 0, 5'd3, 5'd4, 32'h408, 32'h5008, "R11");
    // R13 reserved kinds and idle cycles, R2 single-cycle pulse
    drive(1, 3'd6, 0, 0, 0, 5'd1, 5'd5, 32'h500, 32'h6000, "R13");
    drive(1, 3'd7, 1, 1, 1, 5'd0, 5'd0, 32'h504, 32'h6004, "R13");
    drive(1, 3'd4, 0, 0, 0, 5'd0, 5'd0, 32'h508, 32'h6008, "R2");
    idle();
    idle();
    // R3..R7 sweep of all index pairs for the indirect kind
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        drive(1, 3'd1, 0, 0, 0, 5'(a), 5'(b), 32'(a * 64 + b * 2),
              32'(32'h8000 + a * 4 + b), "R3-R7 sweep");
      end
    end
    idle();
    idle();
    wait (q_v.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule